// File: doc/BRIEF.md
# Multi-Mode Stepper Coil Sequencer

This block turns step pulses into the four coil-drive levels of a unipolar stepper motor. It keeps an up/down position counter. Each rising edge on the step input moves that counter one place forward or back, as the direction input sets. A two-bit mode input then picks one of three coil patterns for the current position: single-coil wave drive, two-coil full step, or eight-state half step. A fourth mode ignores the counter and copies four control inputs straight to the coils.

The step input is passed through a short synchronizer and edge-detected. A pulse advances the motor exactly once however long it stays high. The coil outputs come from a register, so mode changes and direct-mode inputs reach the pins one clock edge later. The power stage, acceleration profiles and any step-rate generator are outside this block.

Top module: `stepper_phase_seq`

## Requirements
- R1: While `rst_ni` is low at a rising clock edge, `coil_o` becomes 0000 after that edge and the position returns to 0. On the first edge with `rst_ni` high, `coil_o` shows the position-0 pattern of the selected mode.
- R2: Each low-to-high transition of `step_i` moves the position by exactly one place, however many cycles `step_i` stays high. Counting the first rising clock edge that samples `step_i` high as edge 1, `coil_o` shows the new pattern after edge SYNC_STAGES+2.
- R3: `dir_up_i` = 1 moves the position forward and 0 moves it backward. The position wraps modulo the sequence length of the active mode: 4 for modes 0 and 1, 8 for mode 2.
- R4: Mode 0 (wave drive) produces the sequence 1000, 0100, 0010, 0001 for positions 0..3. Strings are written as `coil_o[3:0]`.
- R5: Mode 1 (full step) produces 1100, 0110, 0011, 1001 for positions 0..3, so exactly two coils are on in every state.
- R6: Mode 2 (half step) produces 1000, 1100, 0100, 0110, 0010, 0011, 0001, 1001 for positions 0..7.
- R7: In mode 3 (direct), `coil_o` equals the `direct_i` value sampled at the previous rising edge. Step pulses are ignored and the position is held. After leaving mode 3, the pattern for the held position appears. Outside mode 3, `direct_i` has no effect on `coil_o`.
- R8: When the mode changes between counting modes, the position is kept and `coil_o` shows the new mode's pattern one edge later. A position of 4 or more seen in a four-state mode is taken minus 4. The next step continues from that reduced position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| step_i | input | 1 | Step pulse; each rising transition moves one place |
| dir_up_i | input | 1 | 1 = forward, 0 = backward |
| mode_i | input | 2 | 0 wave, 1 full step, 2 half step, 3 direct |
| direct_i | input | COIL_W (4) | Coil levels used in direct mode |
| coil_o | output | COIL_W (4) | Registered coil drive levels, bit 3 leftmost in the sequences |

## Verification
The bench goes after the wrap points in both directions for the four-state and eight-state sequences. A counter with the wrong modulus would jump to a pattern from the wrong table or stall on a repeated state. It holds a step pulse high for several cycles: a design that counts levels instead of edges would run on by several positions. It switches from half step at an odd position into full step and then steps. A design that did not reduce the position would drive a stale or all-off pattern. It also pulses the step input in direct mode and then leaves that mode, which exposes a counter that kept moving while bypassed. A reset in the middle of a run must bring back position 0.

// File: rtl/phase_seq_pkg.sv
package phase_seq_pkg;

   typedef enum logic [1:0] {
      DRV_WAVE   = 2'd0,
      DRV_FULL   = 2'd1,
      DRV_HALF   = 2'd2,
      DRV_DIRECT = 2'd3
   } drive_mode_e;

endpackage

// File: rtl/step_rise_sync.sv
module step_rise_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic step_i,
   output logic rise_o
);

   logic [SYNC_STAGES:0] chain;
   logic                 prev_q;

   assign chain[0] = step_i;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i) begin
         if (!rst_ni) chain[s+1] <= 1'b0;
         else         chain[s+1] <= chain[s];
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= chain[SYNC_STAGES];
   end

   assign rise_o = chain[SYNC_STAGES] & ~prev_q;

   // A held pulse must not produce back-to-back advances (R2)
   assert_single_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);

endmodule

// File: rtl/phase_position_ctr.sv
module phase_position_ctr
   import phase_seq_pkg::*;
#(
   parameter int unsigned COIL_W = 4,
   parameter int unsigned IDX_W  = $clog2(2 * COIL_W)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              adv_i,
   input  logic              dir_up_i,
   input  drive_mode_e       mode_i,
   output logic [IDX_W-1:0]  pos_o
);

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] idx_d;
   logic [IDX_W-1:0] len_m1;
   logic [IDX_W-1:0] pos;

   always_comb begin
      len_m1 = (mode_i == DRV_HALF) ? IDX_W'(2 * COIL_W - 1) : IDX_W'(COIL_W - 1);
      // A raw index left over from half step is folded into the shorter range
      pos    = (idx_q > len_m1) ? idx_q - len_m1 - IDX_W'(1) : idx_q;
      idx_d  = idx_q;
      if (adv_i && (mode_i != DRV_DIRECT)) begin
         if (dir_up_i) idx_d = (pos == len_m1) ? '0 : pos + IDX_W'(1);
         else          idx_d = (pos == '0) ? len_m1 : pos - IDX_W'(1);
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) idx_q <= '0;
      else         idx_q <= idx_d;
   end

   assign pos_o = pos;

   assert_reset_zero_R1: assert property (@(posedge clk_i)
      !rst_ni |=> (idx_q == '0));

   assert_hold_no_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !adv_i |=> $stable(idx_q));

   assert_up_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_i && dir_up_i && (mode_i != DRV_DIRECT) && (pos == len_m1)) |=> (idx_q == '0));

   assert_down_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_i && !dir_up_i && (mode_i != DRV_DIRECT) && (pos == '0)) |=> (idx_q == $past(len_m1)));

   assert_direct_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == DRV_DIRECT) |=> $stable(idx_q));

endmodule

// File: rtl/coil_pattern_gen.sv
module coil_pattern_gen
   import phase_seq_pkg::*;
#(
   parameter int unsigned COIL_W = 4,
   parameter int unsigned IDX_W  = $clog2(2 * COIL_W)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  drive_mode_e       mode_i,
   input  logic [IDX_W-1:0]  pos_i,
   output logic [COIL_W-1:0] wave_o,
   output logic [COIL_W-1:0] full_o,
   output logic [COIL_W-1:0] half_o
);

   // Coil c leads at position K_A and trails its neighbour at position K_B
   for (genvar c = 0; c < COIL_W; c++) begin : g_coil
      localparam int unsigned K_A = COIL_W - 1 - c;
      localparam int unsigned K_B = (2 * COIL_W - 2 - c) % COIL_W;

      assign wave_o[c] = (pos_i == IDX_W'(K_A));
      assign full_o[c] = (pos_i == IDX_W'(K_A)) || (pos_i == IDX_W'(K_B));
      assign half_o[c] = (pos_i == IDX_W'(2 * K_A))     ||
                         (pos_i == IDX_W'(2 * K_A + 1)) ||
                         (pos_i == IDX_W'(2 * K_B + 1));
   end

   assert_wave_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == DRV_WAVE) |-> ($countones(wave_o) == 1));

   assert_full_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == DRV_FULL) |-> ($countones(full_o) == 2));

   assert_half_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == DRV_HALF) |-> (($countones(half_o) == 1) || ($countones(half_o) == 2)));

endmodule

// File: rtl/coil_output_sel.sv
module coil_output_sel
   import phase_seq_pkg::*;
#(
   parameter int unsigned COIL_W  = 4,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  drive_mode_e       mode_i,
   input  logic [COIL_W-1:0] wave_i,
   input  logic [COIL_W-1:0] full_i,
   input  logic [COIL_W-1:0] half_i,
   input  logic [COIL_W-1:0] direct_i,
   output logic [COIL_W-1:0] coil_o
);

   logic [COIL_W-1:0] sel_d;

   always_comb begin
      case (mode_i)
         DRV_WAVE:   sel_d = wave_i;
         DRV_FULL:   sel_d = full_i;
         DRV_HALF:   sel_d = half_i;
         DRV_DIRECT: sel_d = direct_i;
         default:    sel_d = '0;
      endcase
   end

   if (OUT_REG) begin : g_reg
      logic [COIL_W-1:0] coil_q;

      always_ff @(posedge clk_i) begin
         if (!rst_ni) coil_q <= '0;
         else         coil_q <= sel_d;
      end

      assign coil_o = coil_q;

      assert_reset_off_R1: assert property (@(posedge clk_i)
         !rst_ni |=> (coil_o == '0));

      assert_direct_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (mode_i == DRV_DIRECT) |=> (coil_o == $past(direct_i)));
   end else begin : g_comb
      assign coil_o = rst_ni ? sel_d : '0;
   end

endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
   import phase_seq_pkg::*;
#(
   parameter int unsigned COIL_W      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          OUT_REG     = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              step_i,
   input  logic              dir_up_i,
   input  logic [1:0]        mode_i,
   input  logic [COIL_W-1:0] direct_i,
   output logic [COIL_W-1:0] coil_o
);

   localparam int unsigned IDX_W = $clog2(2 * COIL_W);

   if (COIL_W < 3) begin : g_bad_coils
      $error("stepper_phase_seq: COIL_W must be at least 3");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("stepper_phase_seq: SYNC_STAGES must not exceed 4");
   end

   drive_mode_e       mode;
   logic              adv;
   logic [IDX_W-1:0]  pos;
   logic [COIL_W-1:0] wave_pat;
   logic [COIL_W-1:0] full_pat;
   logic [COIL_W-1:0] half_pat;

   assign mode = drive_mode_e'(mode_i);

   step_rise_sync #(
      .SYNC_STAGES (SYNC_STAGES)
   ) u_rise (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (step_i),
      .rise_o (adv)
   );

   phase_position_ctr #(
      .COIL_W (COIL_W),
      .IDX_W  (IDX_W)
   ) u_ctr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .adv_i    (adv),
      .dir_up_i (dir_up_i),
      .mode_i   (mode),
      .pos_o    (pos)
   );

   coil_pattern_gen #(
      .COIL_W (COIL_W),
      .IDX_W  (IDX_W)
   ) u_pat (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode),
      .pos_i  (pos),
      .wave_o (wave_pat),
      .full_o (full_pat),
      .half_o (half_pat)
   );

   coil_output_sel #(
      .COIL_W  (COIL_W),
      .OUT_REG (OUT_REG)
   ) u_sel (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (mode),
      .wave_i   (wave_pat),
      .full_i   (full_pat),
      .half_i   (half_pat),
      .direct_i (direct_i),
      .coil_o   (coil_o)
   );

endmodule

// File: tb/stepper_phase_seq_tb_top.sv
module stepper_phase_seq_tb_top;

   localparam int SYNC = 2;
   localparam int LAT  = SYNC + 2;

   logic       clk = 1'b0;
   logic       rst_ni;
   logic       step_i;
   logic       dir_up_i;
   logic [1:0] mode_i;
   logic [3:0] direct_i;
   logic [3:0] coil_o;

   always #2 clk = ~clk;

   stepper_phase_seq #(
      .COIL_W      (4),
      .SYNC_STAGES (SYNC),
      .OUT_REG     (1'b1)
   ) dut_i (
      .clk_i    (clk),
      .rst_ni   (rst_ni),
      .step_i   (step_i),
      .dir_up_i (dir_up_i),
      .mode_i   (mode_i),
      .direct_i (direct_i),
      .coil_o   (coil_o)
   );

   typedef struct {
      int         due;
      logic [3:0] exp;
      string      tag;
   } item_t;

   item_t      sb_q[$];
   int         cyc = 0;
   int         compared = 0;
   int         mismatched = 0;
   bit         done = 1'b0;
   int         ref_idx = 0;
   int         ref_mode = 0;
   logic [3:0] ref_direct = 4'b0000;

   always @(posedge clk) cyc++;

   // Monitor: compares every expected item in the cycle it falls due
   always @(negedge clk) begin
      item_t it;
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
         it = sb_q.pop_front();
         compared++;
         if (it.due < cyc || coil_o !== it.exp) begin
            mismatched++;
            $display("FAIL %s: coil_o=%b expected=%b (due %0d, at %0d)",
                     it.tag, coil_o, it.exp, it.due, cyc);
         end
      end
   end

   function automatic int seq_len(int m);
      return (m == 2) ? 8 : 4;
   endfunction

   function automatic logic [3:0] exp_pat();
      int p;
      logic [3:0] wave_t[4] = '{4'b1000, 4'b0100, 4'b0010, 4'b0001};
      logic [3:0] full_t[4] = '{4'b1100, 4'b0110, 4'b0011, 4'b1001};
      logic [3:0] half_t[8] = '{4'b1000, 4'b1100, 4'b0100, 4'b0110,
                                4'b0010, 4'b0011, 4'b0001, 4'b1001};
      p = (ref_idx >= seq_len(ref_mode)) ? ref_idx - seq_len(ref_mode) : ref_idx;
      case (ref_mode)
         0:       return wave_t[p];
         1:       return full_t[p];
         2:       return half_t[p];
         default: return ref_direct;
      endcase
   endfunction

   function automatic void model_step(bit up);
      int len;
      int p;
      if (ref_mode == 3) return;
      len = seq_len(ref_mode);
      p = (ref_idx >= len) ? ref_idx - len : ref_idx;
      ref_idx = up ? (p + 1) % len : (p + len - 1) % len;
   endfunction

   task automatic push_val(int delay, logic [3:0] v, string tag);
      item_t it;
      it.due = cyc + delay;
      it.exp = v;
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic push(int delay, string tag);
      push_val(delay, exp_pat(), tag);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(string tag);
      step_i = 1'b0;
      rst_ni = 1'b0;
      ref_idx = 0;
      push_val(1, 4'b0000, tag);
      idle(3);
      rst_ni = 1'b1;
      push(1, tag);
      idle(2);
   endtask

   task automatic set_mode(int m, string tag);
      mode_i = 2'(m);
      ref_mode = m;
      push(1, tag);
      idle(2);
   endtask

   task automatic set_direct(logic [3:0] v, string tag);
      direct_i = v;
      ref_direct = v;
      push(1, tag);
      idle(2);
   endtask

   // Driver: one step pulse held for 'hold' cycles
   task automatic pulse(bit up, int hold, string tag);
      dir_up_i = up;
      step_i = 1'b1;
      model_step(up);
      push(LAT, tag);
      if (hold > 1) push(LAT + hold + 1, tag);
      idle(hold);
      step_i = 1'b0;
      idle(LAT + hold + 3);
   endtask

   initial begin
      rst_ni = 1'b0;
      step_i = 1'b0;
      dir_up_i = 1'b1;
      mode_i = 2'd0;
      direct_i = 4'b0000;
      idle(1);

      // R1: reset state and first pattern in wave mode
      do_reset("R1 reset");

      // R4 / R3: wave forward through wrap, then backward across 0
      pulse(1'b1, 1, "R4 wave up");
      pulse(1'b1, 1, "R4 wave up");
      pulse(1'b1, 1, "R4 wave up");
      pulse(1'b1, 1, "R3 wave up wrap");
      pulse(1'b0, 1, "R3 wave down wrap");

      // R8 / R5: switch to full step at position 3
      set_mode(1, "R8 wave to full");
      pulse(1'b1, 1, "R5 full up wrap");
      pulse(1'b1, 4, "R2 held pulse counts once");
      pulse(1'b0, 1, "R5 full down");
      pulse(1'b0, 1, "R3 full down wrap");

      // R6: half step over a full revolution and back
      set_mode(2, "R8 full to half");
      for (int i = 0; i < 9; i++) pulse(1'b1, 1, "R6 half up");
      for (int i = 0; i < 3; i++) pulse(1'b0, 1, "R6 half down");

      // R7: direct_i has no effect while counting
      set_direct(4'b1010, "R7 direct ignored in half");

      // R8: reach odd position 5 in half, then fold into full
      while (ref_idx != 5) pulse(1'b1, 1, "R6 half up");
      set_mode(1, "R8 half pos 5 to full");
      pulse(1'b1, 1, "R8 step after fold");
      set_mode(2, "R8 full to half");

      // R7: direct pass-through, steps ignored, position held
      set_mode(3, "R7 direct");
      set_direct(4'b0101, "R7 direct follow");
      set_direct(4'b1111, "R7 direct follow");
      pulse(1'b1, 1, "R7 step ignored");
      pulse(1'b0, 2, "R7 step ignored");
      set_mode(2, "R7 held position after direct");

      // R1: reset mid-run in half step
      pulse(1'b1, 1, "R6 half up");
      do_reset("R1 mid-run reset");
      pulse(1'b0, 1, "R3 half down wrap");
      set_mode(0, "R8 half pos 7 to wave");
      pulse(1'b0, 1, "R4 wave down");

      idle(LAT + 4);
      if (sb_q.size() != 0) begin
         mismatched++;
         compared++;
         $display("FAIL R2: %0d expected items never compared, expected 0", sb_q.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog (R1-path): actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule